// File: doc/BRIEF.md
# Receive Descriptor Status Writeback

This block forms the 64-bit control word that a receive DMA engine stores back into a ring descriptor once it has finished with that descriptor's buffer. The engine presents the control word it originally fetched, the index of that descriptor, whether this descriptor closes the frame, and the per-frame status gathered by the MAC. One cycle later the block presents the finished word and the index of the descriptor to use next.

The finished word keeps the ring-wrap marker and the buffer-size field of the fetched word. It zeroes every other bit, sets the first-segment flag according to the block's own frame tracking, and returns ownership to software. The descriptor that closes a frame also receives the length, the error group, the runt and oversize classification, and the broadcast and multicast flags. A frame that overflows one buffer continues into the next descriptor. That descriptor is not marked as a first segment, and it carries no status until the frame ends.

Top module: `rx_desc_writeback`

## Requirements
- R1: Every written-back word has bit 31 (owner; 1 = hardware, 0 = software) equal to 0.
- R2: Bit 63 (end of ring) and bits 42:32 (11-bit buffer size) of the result equal the same bits of the fetched word.
- R3: Every bit outside 63, 42:32, 29, 28, 22:16 and 10:0 is 0 in the result, whatever the fetched word held there.
- R4: Bit 29 (first segment) is 1 on the first writeback after reset or after a closing writeback, and 0 on every writeback that follows a non-closing one.
- R5: On a closing writeback (lastSeg = 1), bit 28 (last segment) is 1 and bits 10:0 carry frameLen.
- R6: On a closing writeback, bit 22 equals oddNibble, bit 19 equals crcErr and bit 18 equals busErr.
- R7: On a closing writeback, bit 21 (runt) is 1 exactly when frameLen < 64.
- R8: On a closing writeback, bit 20 (too long) is 1 exactly when frameLen > 1518.
- R9: On a closing writeback, bit 17 equals isBcast and bit 16 equals isMcast.
- R10: On a non-closing writeback, bits 28, 22:16 and 10:0 are all 0, whatever the status inputs hold.
- R11: nextIdx is 0 when bit 63 of the fetched word is 1, and curIdx + 1 (modulo 2^IDX_W) otherwise.
- R12: outValid is 1 in the cycle after wbValid is sampled high and 0 otherwise. While it is low, outCtrl and nextIdx hold their last values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbValid | input | 1 | A writeback is requested this cycle |
| origCtrl | input | 64 | Control word as fetched from the descriptor |
| curIdx | input | IDX_W | Ring index of that descriptor |
| lastSeg | input | 1 | This descriptor closes the frame |
| frameLen | input | 11 | Total frame length in bytes |
| crcErr | input | 1 | Frame failed its CRC |
| busErr | input | 1 | Bus error during the transfer |
| oddNibble | input | 1 | Frame ended on an odd nibble |
| isBcast | input | 1 | Frame is broadcast |
| isMcast | input | 1 | Frame is multicast |
| outValid | output | 1 | outCtrl and nextIdx were updated on the last edge |
| outCtrl | output | 64 | Control word to write back |
| nextIdx | output | IDX_W | Ring index of the next descriptor |

## Verification
Closing writebacks are swept over every combination of the five status flags. Each combination is tried at lengths 0, 1, 63, 64, 65, 1517, 1518, 1519 and 2047, so the runt and oversize comparisons are probed on both sides of their thresholds. Each fetched word is a different dense bit pattern with the end marker both set and clear, which shows that preserved bits survive and stale bits do not leak through. Chains of non-closing writebacks with all status inputs asserted show that the first flag falls after the opening segment and that status stays out of the continuation descriptors. Idle cycles between writebacks show that the outputs hold their values.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  localparam int LEN_W   = 11;
  localparam int END_B   = 63;
  localparam int SIZE_HI = 42;
  localparam int SIZE_LO = 32;
  localparam int OWN_B   = 31;
  localparam int FIRST_B = 29;
  localparam int LAST_B  = 28;
  localparam int ODD_B   = 22;
  localparam int RUNT_B  = 21;
  localparam int LONG_B  = 20;
  localparam int CRC_B   = 19;
  localparam int BUS_B   = 18;
  localparam int BC_B    = 17;
  localparam int MC_B    = 16;

  typedef struct packed {
    logic load;
    logic markFirst;
    logic writeStatus;
  } wbStrobe_t;
endpackage

// File: rtl/rxwb_ctrl.sv
module rxwb_ctrl
  import rxwb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wbValid,
  input  logic      lastSeg,
  output wbStrobe_t stb,
  output logic      outValid
);
  logic midFrame;

  always_comb begin
    stb.load        = wbValid;
    stb.markFirst   = !midFrame;
    stb.writeStatus = lastSeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midFrame <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= wbValid;
      if (wbValid) midFrame <= !lastSeg;
    end
  end

  // R4
  cont_not_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !lastSeg) |=> !stb.markFirst);

  // R4
  close_then_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && lastSeg) |=> stb.markFirst);
endmodule

// File: rtl/rxwb_dpath.sv
module rxwb_dpath
  import rxwb_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  wbStrobe_t        stb,
  input  logic             outValid,
  input  logic [63:0]      origCtrl,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             crcErr,
  input  logic             busErr,
  input  logic             oddNibble,
  input  logic             isBcast,
  input  logic             isMcast,
  output logic [63:0]      outCtrl,
  output logic [IDX_W-1:0] nextIdx
);
  localparam int SIZE_W = SIZE_HI - SIZE_LO + 1;

  logic [63:0]      newCtrl;
  logic [IDX_W-1:0] newIdx;
  logic             isRunt;
  logic             isLong;

  assign isRunt = (32'(frameLen) < MIN_LEN);
  assign isLong = (32'(frameLen) > MAX_LEN);

  always_comb begin
    newCtrl                   = '0;
    newCtrl[END_B]            = origCtrl[END_B];
    newCtrl[SIZE_HI:SIZE_LO]  = origCtrl[SIZE_HI:SIZE_LO];
    newCtrl[OWN_B]            = 1'b0;
    newCtrl[FIRST_B]          = stb.markFirst;
    if (stb.writeStatus) begin
      newCtrl[LAST_B]         = 1'b1;
      newCtrl[ODD_B]          = oddNibble;
      newCtrl[RUNT_B]         = isRunt;
      newCtrl[LONG_B]         = isLong;
      newCtrl[CRC_B]          = crcErr;
      newCtrl[BUS_B]          = busErr;
      newCtrl[BC_B]           = isBcast;
      newCtrl[MC_B]           = isMcast;
      newCtrl[LEN_W-1:0]      = frameLen;
    end
    newIdx = origCtrl[END_B] ? '0 : curIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCtrl <= '0;
      nextIdx <= '0;
    end else if (stb.load) begin
      outCtrl <= newCtrl;
      nextIdx <= newIdx;
    end
  end

  // R1
  owner_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !outCtrl[OWN_B]);

  // R2
  keep_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (outCtrl[END_B] == $past(origCtrl[END_B])) &&
                 (outCtrl[SIZE_HI:SIZE_LO] == $past(origCtrl[SIZE_HI:SIZE_LO])));

  // R10
  no_status_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.writeStatus) |=> (outCtrl[LAST_B] == 1'b0) &&
      (outCtrl[ODD_B:MC_B] == '0) && (outCtrl[LEN_W-1:0] == '0));

  // R11
  ring_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && origCtrl[END_B]) |=> (nextIdx == '0));

  // R12
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(outCtrl) && $stable(nextIdx)));

  initial begin
    assert (SIZE_W == LEN_W) else $error("buffer size field width mismatch");
  end
endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback
  import rxwb_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wbValid,
  input  logic [63:0]      origCtrl,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             lastSeg,
  input  logic [10:0]      frameLen,
  input  logic             crcErr,
  input  logic             busErr,
  input  logic             oddNibble,
  input  logic             isBcast,
  input  logic             isMcast,
  output logic             outValid,
  output logic [63:0]      outCtrl,
  output logic [IDX_W-1:0] nextIdx
);
  wbStrobe_t stb;

  rxwb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wbValid  (wbValid),
    .lastSeg  (lastSeg),
    .stb      (stb),
    .outValid (outValid)
  );

  rxwb_dpath #(
    .IDX_W   (IDX_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .outValid  (outValid),
    .origCtrl  (origCtrl),
    .curIdx    (curIdx),
    .frameLen  (frameLen),
    .crcErr    (crcErr),
    .busErr    (busErr),
    .oddNibble (oddNibble),
    .isBcast   (isBcast),
    .isMcast   (isMcast),
    .outCtrl   (outCtrl),
    .nextIdx   (nextIdx)
  );
endmodule

// File: tb/rx_desc_writeback_bench.sv
module rx_desc_writeback_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wbValid = 1'b0;
  logic [63:0]      origCtrl = '0;
  logic [IDX_W-1:0] curIdx = '0;
  logic             lastSeg = 1'b0;
  logic [10:0]      frameLen = '0;
  logic             crcErr = 1'b0, busErr = 1'b0, oddNibble = 1'b0;
  logic             isBcast = 1'b0, isMcast = 1'b0;
  logic             outValid;
  logic [63:0]      outCtrl;
  logic [IDX_W-1:0] nextIdx;

  int checks = 0;
  int failures = 0;
  logic benchMid = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_writeback #(.IDX_W(IDX_W)) u_rx_desc_writeback (
    .clk(clk), .rstN(rstN), .wbValid(wbValid), .origCtrl(origCtrl),
    .curIdx(curIdx), .lastSeg(lastSeg), .frameLen(frameLen),
    .crcErr(crcErr), .busErr(busErr), .oddNibble(oddNibble),
    .isBcast(isBcast), .isMcast(isMcast), .outValid(outValid),
    .outCtrl(outCtrl), .nextIdx(nextIdx)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bits the block may drive: 63, 42:32, 29, 28, 22:16, 10:0
  localparam logic [63:0] USED_MASK = 64'h8000_07FF_307F_07FF;

  task automatic doWb(logic [63:0] oc, logic [IDX_W-1:0] ci, logic ls,
                      logic [10:0] len, logic [4:0] fl);
    logic [63:0] e;
    logic [IDX_W-1:0] ei;
    @(negedge clk);
    origCtrl = oc; curIdx = ci; lastSeg = ls; frameLen = len;
    {oddNibble, crcErr, busErr, isBcast, isMcast} = fl;
    wbValid = 1'b1;
    @(negedge clk);
    wbValid = 1'b0;
    e = '0;
    e[63] = oc[63];
    e[42:32] = oc[42:32];
    e[29] = !benchMid;
    if (ls) begin
      e[28] = 1'b1; e[22] = fl[4]; e[19] = fl[3]; e[18] = fl[2];
      e[17] = fl[1]; e[16] = fl[0];
      e[21] = (len < 11'd64);
      e[20] = (len > 11'd1518);
      e[10:0] = len;
    end
    ei = oc[63] ? '0 : ci + 1'b1;
    check("R12 outValid", 64'(outValid), 64'd1);
    check("R1 owner", 64'(outCtrl[31]), 64'd0);
    check("R2 kept fields", {outCtrl[63], outCtrl[42:32]}, {e[63], e[42:32]});
    check("R3 other bits", outCtrl & ~USED_MASK, 64'd0);
    check("R4 first flag", 64'(outCtrl[29]), 64'(e[29]));
    if (ls) begin
      check("R5 last+len", {outCtrl[28], outCtrl[10:0]}, {e[28], e[10:0]});
      check("R6 errors", {outCtrl[22], outCtrl[19], outCtrl[18]}, {e[22], e[19], e[18]});
      check("R7 runt", 64'(outCtrl[21]), 64'(e[21]));
      check("R8 too long", 64'(outCtrl[20]), 64'(e[20]));
      check("R9 class", {outCtrl[17], outCtrl[16]}, {e[17], e[16]});
    end else begin
      check("R10 no status", {outCtrl[28], outCtrl[22:16], outCtrl[10:0]}, 64'd0);
    end
    check("R11 nextIdx", 64'(nextIdx), 64'(ei));
    benchMid = !ls;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [10:0] lens [9];
    logic [63:0] pat;
    logic [63:0] keepC;
    logic [IDX_W-1:0] keepI;
    lens = '{11'd0, 11'd1, 11'd63, 11'd64, 11'd65, 11'd1517, 11'd1518, 11'd1519, 11'd2047};
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset valid", 64'(outValid), 64'd0);
    check("R12 reset ctrl", outCtrl, 64'd0);
    check("R12 reset idx", 64'(nextIdx), 64'd0);
    rstN = 1'b1;
    for (int i = 0; i < 9 * 32; i++) begin
      pat = 64'hA5C3_F0F0_5A3C_0F0F ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
      doWb(pat, IDX_W'(i), 1'b1, lens[i % 9], 5'(i / 9));
    end
    // R4 R10: multi-segment frames with status inputs asserted
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 3; s++) begin
        pat = 64'hFFFF_FFFF_FFFF_FFFF ^ (64'(f * 3 + s) << 61);
        doWb(pat, IDX_W'(15 - s), (s == 2), 11'd1600 + 11'(f), 5'h1F);
      end
    end
    // R11 wrap at the top index without end marker
    doWb(64'h0, '1, 1'b1, 11'd100, 5'h0);
    doWb(64'h8000_0000_0000_0000, 4'd5, 1'b1, 11'd100, 5'h0);
    // R12 hold while idle
    keepC = outCtrl; keepI = nextIdx;
    @(negedge clk);
    origCtrl = '1; curIdx = 4'd3; frameLen = 11'd7;
    @(negedge clk);
    check("R12 idle valid", 64'(outValid), 64'd0);
    check("R12 idle hold", {outCtrl, 60'(keepI)}, {keepC, 60'(nextIdx)});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule